// File: doc/BRIEF.md
# Quad-Capable SPI Read Master

This block is a master-only serial flash controller. It runs one SPI transfer at a time. Every transfer is set up from a flat set of configuration inputs that the block samples on a start pulse:

- the serial clock divider
- which of the chip-select outputs to drive
- the chip-select active level
- the clock rest level
- the capture edge
- a lead gap of 0 to 3 serial clock periods between chip-select assertion and the first clock transition
- the word length
- the number of receive lanes

In single-lane mode the block also shifts a transmit word out on its data output. In dual and quad modes the data output pad is released and read back as an extra receive lane.

A transfer has three phases. The first is a guard of one serial clock period, with chip select inactive. The second is the lead gap, with chip select active and the clock at rest. The third is the shift phase, with one capture per beat. The block reports `busy` for the whole transfer and pulses `done` when chip select drops. The received word then stays on `rx_data` until the next accepted start.

Top module: `qspi_rd_master`

## Requirements
- R1: With cfg_lanes=0 (single, and also the unused code 3), each capture transition takes one bit from `din`, most significant bit first. At the end, `rx_data` holds the cfg_bits_m1+1 received bits right-aligned, with all higher bits zero.
- R2: With cfg_lanes=1 (dual), each capture transition takes two bits, with `din` as the upper bit and `dout_in` as the lower bit. `dout_oe` stays low for the whole transfer.
- R3: With cfg_lanes=2 (quad), each capture transition takes the nibble {qdin2, qdin1, din, dout_in} as bits 3..0. The first nibble ends up most significant.
- R4: In single mode, `dout_oe` is high while chip select is active. At the k-th capture transition, `dout` equals tx_data[cfg_bits_m1-k].
- R5: During the shift phase, every serial clock level lasts exactly N+1 system clocks, where N = cfg_div.
- R6: The first `sclk` transition comes (2L+1)(N+1) system clocks after chip select asserts, where L = cfg_lead.
- R7: During a transfer only cs[cfg_cs_sel] is at its active level: low when cfg_cs_pol=0, high when cfg_cs_pol=1. All other outputs sit at the inactive level, and so do all outputs outside a transfer.
- R8: `sclk` rests at cfg_sclk_pol outside the shift phase. A transfer of B beats makes exactly 2B transitions. cfg_cap_edge=0 captures on transitions away from the rest level; cfg_cap_edge=1 captures on transitions back to it.
- R9: `busy` rises in the cycle after the edge that accepts a start. `busy` falls, chip select drops and `done` pulses for one cycle all at the same moment, (2+2L+2B)(N+1) clocks after the accepting edge. `rx_data` then stays unchanged until the next start.
- R10: A start pulse while `busy` is high is ignored. Configuration inputs changed at that time do not alter the running transfer.
- R11: Before every chip-select assertion, chip select has been inactive for at least 2(N+1) system clocks.
- R12: After reset, `busy`, `done`, `sclk`, `dout_oe` and `rx_data` are zero, and all chip-select outputs are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| cfg_div | input | DIV_W | Divider N; serial clock period is 2(N+1) clocks |
| cfg_cs_sel | input | $clog2(NUM_CS) | Index of the chip select to drive |
| cfg_cs_pol | input | 1 | Chip-select active level (0 low, 1 high) |
| cfg_sclk_pol | input | 1 | Serial clock rest level |
| cfg_cap_edge | input | 1 | 0 capture leaving rest, 1 capture returning to rest |
| cfg_lead | input | 2 | Lead gap in serial clock periods |
| cfg_bits_m1 | input | $clog2(WORD_W) | Word length minus one |
| cfg_lanes | input | 2 | 0 single, 1 dual, 2 quad |
| tx_data | input | WORD_W | Word sent on dout in single mode |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_data | output | WORD_W | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| cs | output | NUM_CS | Chip-select outputs |
| dout | output | 1 | Serial data output |
| dout_oe | output | 1 | Output enable for the dout pad |
| dout_in | input | 1 | Readback of the dout pad (lane 0 in wide modes) |
| din | input | 1 | Primary serial data input |
| qdin1 | input | 1 | Extra receive lane 2 |
| qdin2 | input | 1 | Extra receive lane 3 |

## Verification
The embedded properties watch several rules on every cycle:

- the single-cycle done pulse that coincides with busy falling
- one active chip select during a transfer, and none outside it
- the clock resting while not shifting
- the guard time before chip select asserts
- ignored starts leaving the latched setup untouched
- the lane-to-word bit mapping at each capture
- the restart of the divider

Only the bench's sweep can show the properties that depend on the whole transfer:

- the received and transmitted words are correct
- the lead gap and half-period lengths are exact
- the transition count matches the beat count
- the total transfer length is exact

The sweep covers both clock rest levels, both capture edges, all three lane modes, three divider values, all four lead values and three word lengths.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;
   typedef enum logic [1:0] {
      LANE_X1 = 2'd0,
      LANE_X2 = 2'd1,
      LANE_X4 = 2'd2
   } lane_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_GUARD = 2'd1,
      ST_LEAD  = 2'd2,
      ST_SHIFT = 2'd3
   } xfer_state_e;
endpackage

// File: rtl/qspi_sclk_div.sv
module qspi_sclk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (tick)       cnt <= '0;
      else                 cnt <= cnt + DIV_W'(1);
   end

   // Counter restarts from zero: first tick after idle only comes at once for N=0
   assert_div_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run) |=> (!tick || div == '0));
endmodule

// File: rtl/qspi_lane_gather.sv
module qspi_lane_gather import qspi_rd_pkg::*; #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cap,
   input  lane_mode_e        mode,
   input  logic [3:0]        lane_in,
   output logic [WORD_W-1:0] rx
);
   logic [WORD_W-1:0] nxt;

   always_comb begin
      unique case (mode)
         LANE_X2: nxt = {rx[WORD_W-3:0], lane_in[1:0]};
         LANE_X4: nxt = {rx[WORD_W-5:0], lane_in};
         default: nxt = {rx[WORD_W-2:0], lane_in[1]};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rx <= '0;
      else if (clr)  rx <= '0;
      else if (cap)  rx <= nxt;
   end

   assert_x1_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && !clr && mode == LANE_X1) |=> rx[0] == $past(lane_in[1]));
   assert_x2_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && !clr && mode == LANE_X2) |=> rx[1:0] == $past(lane_in[1:0]));
   assert_x4_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && !clr && mode == LANE_X4) |=> rx[3:0] == $past(lane_in));
endmodule

// File: rtl/qspi_cs_fanout.sv
module qspi_cs_fanout #(
   parameter int NUM_CS = 4,
   parameter int SW     = 2
) (
   input  logic              on,
   input  logic [SW-1:0]     sel,
   input  logic              pol,
   output logic [NUM_CS-1:0] cs
);
   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign cs[i] = (on && sel == SW'(i)) ? pol : ~pol;
   end
endmodule

// File: rtl/qspi_rd_master.sv
module qspi_rd_master import qspi_rd_pkg::*; #(
   parameter int WORD_W    = 32,
   parameter int DIV_W     = 8,
   parameter int NUM_CS    = 4,
   parameter int MAX_LANES = 4,
   localparam int SW       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int BW       = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [SW-1:0]     cfg_cs_sel,
   input  logic              cfg_cs_pol,
   input  logic              cfg_sclk_pol,
   input  logic              cfg_cap_edge,
   input  logic [1:0]        cfg_lead,
   input  logic [BW-1:0]     cfg_bits_m1,
   input  logic [1:0]        cfg_lanes,
   input  logic [WORD_W-1:0] tx_data,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] rx_data,
   output logic              sclk,
   output logic [NUM_CS-1:0] cs,
   output logic              dout,
   output logic              dout_oe,
   input  logic              dout_in,
   input  logic              din,
   input  logic              qdin1,
   input  logic              qdin2
);
   localparam int TW = BW + 2;
   localparam int GW = DIV_W + 3;

   initial begin
      assert (WORD_W >= 8 && WORD_W % 4 == 0) else $error("WORD_W must be a multiple of 4, at least 8");
      assert (NUM_CS >= 2) else $error("NUM_CS must be at least 2");
      assert (MAX_LANES == 1 || MAX_LANES == 2 || MAX_LANES == 4) else $error("MAX_LANES must be 1, 2 or 4");
   end

   xfer_state_e       state;
   logic [TW-1:0]     tcnt, last_q, lead_end;
   logic [DIV_W-1:0]  div_q;
   logic [SW-1:0]     sel_q;
   logic              cs_pol_q, cpol_q, edge_q, phase, done_q;
   logic [1:0]        lead_q;
   lane_mode_e        mode_q, req_mode;
   logic [WORD_W-1:0] tx_sh, tx_load;
   logic [BW:0]       bits_w, beats_w, sh_w;
   logic [TW-1:0]     last_w;
   logic              accept, run, tick, cs_on, in_shift, cap, launch, fin;

   // Clamp the requested lane mode to what this instance was built for
   if (MAX_LANES >= 4) begin : g_lane4
      assign req_mode = (cfg_lanes == 2'd3) ? LANE_X1 : lane_mode_e'(cfg_lanes);
   end else if (MAX_LANES == 2) begin : g_lane2
      assign req_mode = (cfg_lanes == 2'd1) ? LANE_X2 : LANE_X1;
   end else begin : g_lane1
      assign req_mode = LANE_X1;
   end

   always_comb begin
      bits_w = {1'b0, cfg_bits_m1} + (BW+1)'(1);
      unique case (req_mode)
         LANE_X2: beats_w = bits_w >> 1;
         LANE_X4: beats_w = bits_w >> 2;
         default: beats_w = bits_w;
      endcase
      last_w  = {beats_w, 1'b0} - TW'(1);
      sh_w    = (BW+1)'(WORD_W) - bits_w;
      tx_load = tx_data << sh_w;
   end

   assign accept   = start && (state == ST_IDLE);
   assign run      = (state != ST_IDLE);
   assign in_shift = (state == ST_SHIFT);
   assign cs_on    = (state == ST_LEAD) || in_shift;
   assign lead_end = TW'({lead_q, 1'b0}) - TW'(1);
   assign cap      = tick && in_shift && (tcnt[0] == edge_q);
   assign launch   = tick && in_shift && (tcnt[0] != edge_q) && (tcnt != '0);
   assign fin      = tick && in_shift && (tcnt == last_q);

   qspi_sclk_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .tick(tick));

   qspi_lane_gather #(.WORD_W(WORD_W)) u_gather (
      .clk(clk), .rst_n(rst_n), .clr(accept), .cap(cap), .mode(mode_q),
      .lane_in({qdin2, qdin1, din, dout_in}), .rx(rx_data));

   qspi_cs_fanout #(.NUM_CS(NUM_CS), .SW(SW)) u_cs (
      .on(cs_on), .sel(sel_q), .pol(cs_pol_q), .cs(cs));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         tcnt     <= '0;
         last_q   <= '0;
         div_q    <= '0;
         sel_q    <= '0;
         cs_pol_q <= 1'b0;
         cpol_q   <= 1'b0;
         edge_q   <= 1'b0;
         lead_q   <= 2'd0;
         mode_q   <= LANE_X1;
         phase    <= 1'b0;
         tx_sh    <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= fin;
         if (accept) begin
            state    <= ST_GUARD;
            tcnt     <= '0;
            last_q   <= last_w;
            div_q    <= cfg_div;
            sel_q    <= cfg_cs_sel;
            cs_pol_q <= cfg_cs_pol;
            cpol_q   <= cfg_sclk_pol;
            edge_q   <= cfg_cap_edge;
            lead_q   <= cfg_lead;
            mode_q   <= req_mode;
            phase    <= 1'b0;
            tx_sh    <= tx_load;
         end else if (tick) begin
            unique case (state)
               ST_GUARD: begin
                  if (tcnt == TW'(1)) begin
                     tcnt  <= '0;
                     state <= (lead_q == 2'd0) ? ST_SHIFT : ST_LEAD;
                  end else begin
                     tcnt <= tcnt + TW'(1);
                  end
               end
               ST_LEAD: begin
                  if (tcnt == lead_end) begin
                     tcnt  <= '0;
                     state <= ST_SHIFT;
                  end else begin
                     tcnt <= tcnt + TW'(1);
                  end
               end
               ST_SHIFT: begin
                  phase <= ~phase;
                  if (launch) tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
                  if (fin) begin
                     state <= ST_IDLE;
                     tcnt  <= '0;
                  end else begin
                     tcnt <= tcnt + TW'(1);
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign busy    = run;
   assign done    = done_q;
   assign sclk    = phase ^ cpol_q;
   assign dout    = tx_sh[WORD_W-1];
   assign dout_oe = cs_on && (mode_q == LANE_X1);

   // Inactive-time counter used only by the guard-time property
   logic [GW-1:0] gap_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                gap_cnt <= '0;
      else if (cs_on)            gap_cnt <= '0;
      else if (gap_cnt != '1)    gap_cnt <= gap_cnt + GW'(1);
   end

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   assert_cs_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_on |-> (cs == {NUM_CS{~cs_pol_q}}));
   assert_cs_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_on |-> ($countones(cs ^ {NUM_CS{~cs_pol_q}}) == 1));
   assert_sclk_rest_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_shift |-> (sclk == cpol_q));
   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(sel_q) && $stable(mode_q) && $stable(last_q) && $stable(div_q)));
   assert_cs_guard_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_on) |-> (gap_cnt >= GW'({div_q, 1'b0}) + GW'(2)));
endmodule

// File: tb/sim_qspi_rd_master.sv
module sim_qspi_rd_master;
   localparam int WW  = 16;
   localparam int DW  = 3;
   localparam int NCS = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, start, cfg_cs_pol, cfg_sclk_pol, cfg_cap_edge;
   logic [DW-1:0] cfg_div;
   logic [1:0]    cfg_cs_sel, cfg_lead, cfg_lanes;
   logic [3:0]    cfg_bits_m1;
   logic [WW-1:0] tx_data;
   logic          busy, done, sclk, dout, dout_oe;
   logic [WW-1:0] rx_data;
   logic [NCS-1:0] cs;
   logic          d_doi, d_din, d_q1, d_q2;

   qspi_rd_master #(.WORD_W(WW), .DIV_W(DW), .NUM_CS(NCS), .MAX_LANES(4)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_div(cfg_div),
      .cfg_cs_sel(cfg_cs_sel), .cfg_cs_pol(cfg_cs_pol), .cfg_sclk_pol(cfg_sclk_pol),
      .cfg_cap_edge(cfg_cap_edge), .cfg_lead(cfg_lead), .cfg_bits_m1(cfg_bits_m1),
      .cfg_lanes(cfg_lanes), .tx_data(tx_data), .busy(busy), .done(done),
      .rx_data(rx_data), .sclk(sclk), .cs(cs), .dout(dout), .dout_oe(dout_oe),
      .dout_in(d_doi), .din(d_din), .qdin1(d_q1), .qdin2(d_q2));

   int n_chk = 0, n_bad = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Model of the slave side, configured by the main sequence
   int m_w = 1, m_bits = 8, m_beats = 8, m_div = 0, m_sel = 0;
   bit m_pol = 0, m_cpol = 0, m_edge = 0;
   logic [WW-1:0] m_rx = '0;
   int cyc = 0, edges = 0, lead_meas = 0, gap_meas = 0, kk = 0;
   int err_half = 0, err_cs = 0, err_oe = 0;
   int cs_assert_cyc = 0, last_edge_cyc = 0, last_deassert = 0;
   logic [WW-1:0] txcap = '0;
   bit was_act = 0, prev_sclk = 0;

   task automatic drive_chunk(input int k);
      logic [3:0] v;
      logic [3:0] junk;
      junk = 4'($urandom);
      v = junk;
      if (k < m_beats)
         v = 4'((m_rx >> (m_bits - (k + 1) * m_w)) & WW'((1 << m_w) - 1));
      d_q2 = junk[3]; d_q1 = junk[2]; d_din = junk[1]; d_doi = junk[0];
      case (m_w)
         1: d_din = v[0];
         2: {d_din, d_doi} = v[1:0];
         default: {d_q2, d_q1, d_din, d_doi} = v;
      endcase
   endtask

   always @(negedge clk) begin
      logic [NCS-1:0] act;
      cyc++;
      act = '0;
      if (busy) act = m_pol ? cs : ~cs;
      if (act != '0) begin
         if (!was_act) begin
            cs_assert_cyc = cyc;
            gap_meas = cyc - last_deassert;
            kk = 0;
            drive_chunk(0);
         end
         if (act != (NCS'(1) << m_sel)) err_cs++;
      end
      if (busy && act == '0 && cs != {NCS{~m_pol}}) err_cs++;
      if ((act != '0 || was_act) && sclk != prev_sclk) begin
         edges++;
         if (edges == 1) lead_meas = cyc - cs_assert_cyc;
         else if (cyc - last_edge_cyc != m_div + 1) err_half++;
         last_edge_cyc = cyc;
         if ((sclk != m_cpol) ^ m_edge) begin
            if (m_w == 1) txcap = {txcap[WW-2:0], dout};
            if (act != '0 && dout_oe != (m_w == 1)) err_oe++;
            kk++;
            drive_chunk(kk);
         end
      end
      if (was_act && act == '0) last_deassert = cyc;
      was_act = (act != '0);
      prev_sclk = sclk;
   end

   task automatic run_xfer(input int idx, input int cp, input int ed, input int ln,
                           input int dv, input int ld);
      int bits, w, nd, beats, expm, elapsed;
      bit inj;
      logic [WW-1:0] mask, txv, rxv;
      string rq;
      bits = (idx % 3 == 0) ? 16 : ((idx % 3 == 1) ? 12 : 8);
      w = (ln == 0) ? 1 : ((ln == 1) ? 2 : 4);
      nd = (dv == 2) ? 3 : dv;
      beats = bits / w;
      mask = WW'((32'd1 << bits) - 1);
      inj = (idx % 5 == 2);
      rq = (ln == 0) ? "R1" : ((ln == 1) ? "R2" : "R3");
      txv = WW'($urandom);
      rxv = WW'($urandom);
      m_w = w; m_bits = bits; m_beats = beats; m_div = nd; m_sel = idx % 4;
      m_pol = bit'((idx / 4) % 2); m_cpol = bit'(cp); m_edge = bit'(ed); m_rx = rxv;
      edges = 0; err_half = 0; err_cs = 0; err_oe = 0; txcap = '0; lead_meas = -1;
      cfg_div = DW'(nd); cfg_cs_sel = 2'(m_sel); cfg_cs_pol = m_pol;
      cfg_sclk_pol = m_cpol; cfg_cap_edge = m_edge; cfg_lead = 2'(ld);
      cfg_bits_m1 = 4'(bits - 1); cfg_lanes = 2'(ln); tx_data = txv;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R9", "busy after start", busy, 1);
      elapsed = 0;
      while (!done && elapsed < 2000) begin
         @(negedge clk);
         elapsed++;
         if (inj && elapsed == 4) begin
            cfg_cs_sel = 2'(m_sel + 1); cfg_lanes = 2'((ln + 1) % 3);
            cfg_bits_m1 = 4'd3; cfg_div = DW'(nd + 1);
            start = 1'b1;
         end
         if (elapsed == 5) start = 1'b0;
      end
      expm = (2 + 2 * ld + 2 * beats) * (nd + 1);
      check(elapsed == expm, "R9", "cycles to done", elapsed, expm);
      check(busy == 1'b0, "R9", "busy with done", busy, 0);
      @(negedge clk);
      check(done == 1'b0, "R9", "done width", done, 0);
      check(rx_data == (rxv & mask), rq, "received word", rx_data, rxv & mask);
      if (inj)
         check(rx_data == (rxv & mask) && elapsed == expm, "R10", "start while busy",
               rx_data, rxv & mask);
      check(edges == 2 * beats, "R8", "transition count", edges, 2 * beats);
      check(lead_meas == (2 * ld + 1) * (nd + 1), "R6", "lead gap", lead_meas,
            (2 * ld + 1) * (nd + 1));
      check(err_half == 0, "R5", "half period errors", err_half, 0);
      check(err_cs == 0, "R7", "chip select errors", err_cs, 0);
      check(err_oe == 0, (w == 1) ? "R4" : "R2", "output enable errors", err_oe, 0);
      if (w == 1) check(txcap == (txv & mask), "R4", "transmitted word", txcap, txv & mask);
      check(gap_meas >= 2 * (nd + 1), "R11", "inactive gap", gap_meas, 2 * (nd + 1));
      repeat (2) @(negedge clk);
      check(sclk == m_cpol, "R8", "rest level", sclk, m_cpol);
      check(rx_data == (rxv & mask), "R9", "word held", rx_data, rxv & mask);
   endtask

   initial begin
      int idx;
      rst_n = 1'b0; start = 1'b0; cfg_div = '0; cfg_cs_sel = '0; cfg_cs_pol = 1'b0;
      cfg_sclk_pol = 1'b0; cfg_cap_edge = 1'b0; cfg_lead = '0; cfg_bits_m1 = '0;
      cfg_lanes = '0; tx_data = '0; d_doi = 1'b0; d_din = 1'b0; d_q1 = 1'b0; d_q2 = 1'b0;
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, "R12", "busy/done at reset", {busy, done}, 0);
      check(cs == '1, "R12", "chip selects at reset", cs, 4'hF);
      check(sclk == 1'b0 && dout_oe == 1'b0, "R12", "sclk/oe at reset", {sclk, dout_oe}, 0);
      check(rx_data == '0, "R12", "rx_data at reset", rx_data, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      idx = 0;
      for (int cp = 0; cp < 2; cp++)
         for (int ed = 0; ed < 2; ed++)
            for (int ln = 0; ln < 3; ln++)
               for (int dv = 0; dv < 3; dv++)
                  for (int ld = 0; ld < 4; ld++) begin
                     run_xfer(idx, cp, ed, ln, dv, ld);
                     idx++;
                  end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule